// File: doc/BRIEF.md
# Seconds and Sub-second Alarm Timer

This block is the timekeeping core of a low-power clock domain. A one-cycle `tick` strobe at 32.768 kHz advances a 15-bit fraction counter. When that counter wraps, a 32-bit whole-seconds counter advances in the same tick, so the pair is never read in a half-updated state. Each counter has its own run bit, its own alarm value and its own interrupt enable.

A counter whose alarm is reached sets a sticky flag. The flag stays set until software writes a one to its bit in the flag register. The interrupt line is the OR of each flag masked by its enable. Software stops a counter, writes its starting value, and then restarts it. All registers sit on a simple word interface clocked in the slow domain. Reads are returned one cycle after the address is presented.

Top module: `tick_alarm_timer`

## Requirements
- R1: After a synchronous reset every register (control, both counters, both alarms, flags) reads 0 and `irq` is 0.
- R2: With control bit 0 (fraction run) set, the fraction counter at address 1 advances by one on every cycle with `tick` high and wraps from 32767 to 0. With bit 0 clear it holds its value.
- R3: The seconds counter at address 2 advances by one in the same cycle that the fraction counter wraps to 0, but only while control bit 1 (seconds run) is set. Otherwise it holds.
- R4: A write to address 1 or 2 loads that counter only while its run bit is clear; while it runs, the write is ignored. Addresses 3 (fraction alarm) and 4 (seconds alarm) are always writable.
- R5: Flag bit 0 is set when the fraction counter advances onto the fraction alarm value; flag bit 1 is set when the seconds counter advances onto the seconds alarm value. A stopped counter never sets its flag.
- R6: Flags at address 5 are sticky and are cleared by writing 1 to the bit. If a set and a clear meet in the same cycle, the set wins.
- R7: `irq` is high exactly when (flag 0 and control bit 2) or (flag 1 and control bit 3), and it changes in the same cycle that the flag or enable becomes readable.
- R8: Writing 0 to control (address 0) stops both counters and drops `irq` at the next edge.
- R9: `rd_data` shows, one cycle after `rd_addr` is sampled, the addressed register zero-extended. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle 32.768 kHz count strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Registered alarm interrupt |

## Verification
The counters are driven with three tick patterns. Ticks on every cycle expose the wrap and the carry into the seconds counter in the same tick. Ticks on every other cycle show that the counters respond to the strobe and not to the clock. No ticks at all show that the stored state holds still while software loads and reads it. A run of over 32768 ticks with the seconds counter stopped separates a carry that is gated by the seconds run bit from one that is not. A clear written in the same cycle that an alarm fires separates set-wins priority from clear-wins priority. Writes to a running counter show whether the load guard is honoured.

// File: rtl/tat_pkg.sv
package tat_pkg;
  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_FRAC   = 3'd1,
    A_SECS   = 3'd2,
    A_FALM   = 3'd3,
    A_SALM   = 3'd4,
    A_FLAG   = 3'd5
  } tat_addr_e;

  typedef struct packed {
    logic secs_ie;
    logic frac_ie;
    logic secs_run;
    logic frac_run;
  } tat_ctrl_t;

  localparam int CTRL_W = $bits(tat_ctrl_t);
  localparam int NUM_ALARMS = 2;
endpackage

// File: rtl/tat_counter.sv
module tat_counter #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] alarm,
  output logic [W-1:0] cnt,
  output logic         wrap,
  output logic         hit
);
  logic [W-1:0] cnt_inc;

  assign cnt_inc = cnt + {{(W-1){1'b0}}, 1'b1};
  assign wrap    = adv && (&cnt);
  assign hit     = adv && (cnt_inc == alarm);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (adv) cnt <= cnt_inc;
  end

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!adv && !ld) |=> $stable(cnt));
endmodule

// File: rtl/tat_regs.sv
module tat_regs
  import tat_pkg::*;
#(
  parameter int FRAC_W = 15,
  parameter int SECS_W = 32,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DW-1:0]     wr_data,
  output tat_ctrl_t         ctrl_q,
  output tat_ctrl_t         ctrl_d,
  output logic [FRAC_W-1:0] frac_alm,
  output logic [SECS_W-1:0] secs_alm
);
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en && wr_addr == A_CTRL) ctrl_d = tat_ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      frac_alm <= '0;
      secs_alm <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_en && wr_addr == A_FALM) frac_alm <= wr_data[FRAC_W-1:0];
      if (wr_en && wr_addr == A_SALM) secs_alm <= wr_data[SECS_W-1:0];
    end
  end
endmodule

// File: rtl/tat_flags.sv
module tat_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags_q,
  output logic [N-1:0] flags_d
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    assign flags_d[i] = set[i] | (flags_q[i] & ~clr[i]);

    always_ff @(posedge clk) begin
      if (rst) flags_q[i] <= 1'b0;
      else     flags_q[i] <= flags_d[i];
    end

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      (flags_q[i] && !clr[i]) |=> flags_q[i]);
  end
endmodule

// File: rtl/tick_alarm_timer.sv
module tick_alarm_timer
  import tat_pkg::*;
#(
  parameter int FRAC_W = 15,
  parameter int SECS_W = 32,
  parameter int DW     = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam int NA = NUM_ALARMS;

  tat_ctrl_t         ctrl_q, ctrl_d;
  logic [FRAC_W-1:0] frac_alm, frac_cnt;
  logic [SECS_W-1:0] secs_alm, secs_cnt;
  logic              frac_adv, secs_adv, frac_wrap, secs_wrap, frac_hit, secs_hit;
  logic              frac_ld, secs_ld;
  logic [NA-1:0]     fl_set, fl_clr, flags_q, flags_d;

  tat_regs #(.FRAC_W(FRAC_W), .SECS_W(SECS_W), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .ctrl_d(ctrl_d), .frac_alm(frac_alm), .secs_alm(secs_alm)
  );

  assign frac_adv = tick && ctrl_q.frac_run;
  assign secs_adv = frac_wrap && ctrl_q.secs_run;
  assign frac_ld  = wr_en && (wr_addr == A_FRAC) && !ctrl_q.frac_run;
  assign secs_ld  = wr_en && (wr_addr == A_SECS) && !ctrl_q.secs_run;

  tat_counter #(.W(FRAC_W)) u_frac (
    .clk(clk), .rst(rst), .adv(frac_adv), .ld(frac_ld),
    .ld_val(wr_data[FRAC_W-1:0]), .alarm(frac_alm),
    .cnt(frac_cnt), .wrap(frac_wrap), .hit(frac_hit)
  );

  tat_counter #(.W(SECS_W)) u_secs (
    .clk(clk), .rst(rst), .adv(secs_adv), .ld(secs_ld),
    .ld_val(wr_data[SECS_W-1:0]), .alarm(secs_alm),
    .cnt(secs_cnt), .wrap(secs_wrap), .hit(secs_hit)
  );

  assign fl_set = {secs_hit, frac_hit};
  assign fl_clr = (wr_en && wr_addr == A_FLAG) ? wr_data[NA-1:0] : '0;

  tat_flags #(.N(NA)) u_flags (
    .clk(clk), .rst(rst), .set(fl_set), .clr(fl_clr),
    .flags_q(flags_q), .flags_d(flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      rd_data <= '0;
    end else begin
      irq <= |(flags_d & {ctrl_d.secs_ie, ctrl_d.frac_ie});
      case (rd_addr)
        A_CTRL:  rd_data <= DW'(ctrl_q);
        A_FRAC:  rd_data <= DW'(frac_cnt);
        A_SECS:  rd_data <= DW'(secs_cnt);
        A_FALM:  rd_data <= DW'(frac_alm);
        A_SALM:  rd_data <= DW'(secs_alm);
        A_FLAG:  rd_data <= DW'(flags_q);
        default: rd_data <= '0;
      endcase
    end
  end

  assert_same_tick_carry_R3: assert property (@(posedge clk) disable iff (rst)
    (frac_wrap && ctrl_q.secs_run && !secs_wrap) |=>
      (secs_cnt == $past(secs_cnt) + 1'b1) && (frac_cnt == '0));

  assert_flag_needs_run_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_q[0]) |-> $past(ctrl_q.frac_run));

  assert_ctrl_zero_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_CTRL && wr_data[CTRL_W-1:0] == '0) |=> !irq);
endmodule

// File: tb/sim_tick_alarm_timer.sv
module sim_tick_alarm_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tick_mode = 0;  // 0 manual, 1 every other cycle
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  tick_alarm_timer u0 (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // behavioural reference
  bit [3:0]  m_ctrl;
  int        m_frac, m_falm;
  bit [31:0] m_secs, m_salm;
  bit [1:0]  m_flag;
  bit [31:0] e_rd;
  bit        e_irq;
  bit        started = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_ctrl = 0; m_frac = 0; m_falm = 0; m_secs = 0; m_salm = 0; m_flag = 0;
      e_rd = 0; e_irq = 0; started = 1;
    end else begin
      bit fa, fw, sa, hf, hs;
      int nf; bit [31:0] ns; bit [1:0] nfl; bit [3:0] nc;
      case (rd_addr)
        3'd0: e_rd = {28'd0, m_ctrl};
        3'd1: e_rd = 32'(m_frac);
        3'd2: e_rd = m_secs;
        3'd3: e_rd = 32'(m_falm);
        3'd4: e_rd = m_salm;
        3'd5: e_rd = {30'd0, m_flag};
        default: e_rd = 0;
      endcase
      fa = tick && m_ctrl[0];
      fw = fa && (m_frac == 32767);
      sa = fw && m_ctrl[1];
      nf = fa ? (m_frac + 1) % 32768 : m_frac;
      ns = sa ? m_secs + 1 : m_secs;
      hf = fa && (nf == m_falm);
      hs = sa && (ns == m_salm);
      nfl = m_flag;
      nc = m_ctrl;
      if (wr_en) begin
        case (wr_addr)
          3'd0: nc = wr_data[3:0];
          3'd1: if (!m_ctrl[0]) nf = int'(wr_data[14:0]);
          3'd2: if (!m_ctrl[1]) ns = wr_data;
          3'd3: m_falm = int'(wr_data[14:0]);
          3'd4: m_salm = wr_data;
          3'd5: nfl = nfl & ~wr_data[1:0];
          default: ;
        endcase
      end
      if (hf) nfl[0] = 1'b1;
      if (hs) nfl[1] = 1'b1;
      m_frac = nf; m_secs = ns; m_flag = nfl; m_ctrl = nc;
      e_irq = (nfl[0] && nc[2]) || (nfl[1] && nc[3]);
    end
  end

  function automatic string tag_of(input logic [2:0] a, input bit in_rst);
    if (in_rst) return "R1";
    case (a)
      3'd0: return "R8";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3, 3'd4: return "R4";
      3'd5: return "R6";
      default: return "R9";
    endcase
  endfunction

  // per-cycle comparison against the reference (read path R9, irq R7)
  logic [2:0] last_rd_addr;
  always @(posedge clk) last_rd_addr <= rd_addr;
  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (rd_data !== e_rd) begin
        errors++;
        $display("FAIL %s/R9 cycle %0d addr %0d: rd_data actual %0h expected %0h",
                 tag_of(last_rd_addr, rst), cyc, last_rd_addr, rd_data, e_rd);
      end
      checks++;
      if (irq !== e_irq) begin
        errors++;
        $display("FAIL R7 cycle %0d: irq actual %0b expected %0b", cyc, irq, e_irq);
      end
    end
  end

  // tick generator for the alternating pattern
  always @(negedge clk) if (tick_mode == 1) tick <= ~tick;

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s addr %0d: actual %0h expected %0h", tag, a, rd_data, exp);
    end
  endtask

  task automatic irq_check(input bit exp, input string tag);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq: actual %0b expected %0b", tag, irq, exp);
    end
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    for (int a = 0; a < 6; a++) rd_check(3'(a), 32'd0, "R1");
    irq_check(1'b0, "R1");

    // R4: load while stopped
    wr(3'd1, 32'd32760);
    wr(3'd2, 32'd7);
    wr(3'd3, 32'd32765);
    wr(3'd4, 32'd8);
    rd_check(3'd1, 32'd32760, "R4");
    rd_check(3'd2, 32'd7, "R4");

    // start everything, 10 back-to-back ticks: wrap at tick 8
    wr(3'd0, 32'hF);
    ticks(10);
    rd_check(3'd1, 32'd2, "R2");
    rd_check(3'd2, 32'd8, "R3");
    rd_check(3'd5, 32'd3, "R5");
    irq_check(1'b1, "R7");

    // R4: write to a running counter is ignored
    wr(3'd1, 32'd100);
    wr(3'd2, 32'd100);
    rd_check(3'd1, 32'd2, "R4");
    rd_check(3'd2, 32'd8, "R4");

    // R6: write-one-to-clear, one bit at a time
    wr(3'd5, 32'd1);
    rd_check(3'd5, 32'd2, "R6");
    irq_check(1'b1, "R7");
    wr(3'd5, 32'd2);
    rd_check(3'd5, 32'd0, "R6");
    irq_check(1'b0, "R7");

    // R3: seconds stopped, fraction wraps without carry
    wr(3'd0, 32'h5);
    ticks(32770);
    rd_check(3'd1, 32'd4, "R2");
    rd_check(3'd2, 32'd8, "R3");
    rd_check(3'd5, 32'd1, "R5");
    wr(3'd2, 32'd100);
    rd_check(3'd2, 32'd100, "R4");

    // R7: enable masks a pending flag
    wr(3'd0, 32'h1);
    irq_check(1'b0, "R7");

    // alternating ticks, full enables, reference compared every cycle
    wr(3'd5, 32'd3);
    wr(3'd3, 32'd900);
    wr(3'd0, 32'hF);
    tick_mode = 1;
    repeat (2000) @(negedge clk);
    tick_mode = 0;
    tick = 1'b0;
    rd_check(3'd5, 32'd1, "R5");

    // R8: control zero stops counting and drops irq
    wr(3'd0, 32'd0);
    irq_check(1'b0, "R8");
    rd_check(3'd1, 32'd1004, "R8");
    ticks(20);
    rd_check(3'd1, 32'd1004, "R8");
    rd_check(3'd0, 32'd0, "R8");

    // R6: set wins over a clear in the same cycle
    wr(3'd1, 32'd9);
    wr(3'd3, 32'd10);
    wr(3'd0, 32'h5);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd5; wr_data = 32'd1;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd_check(3'd5, 32'd1, "R6");
    irq_check(1'b1, "R6");

    // R9: unused address reads zero
    rd_check(3'd7, 32'd0, "R9");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule